// File: doc/BRIEF.md
# Branch Target Landing Checker

This block sits beside an instruction issue stage and judges, for every issued instruction, whether it is an acceptable place for an indirect branch to land on a guarded page. It keeps a small branch-type register holding the kind of branch that has just been taken. For the first instruction after such a branch on a guarded page, it compares the instruction's encoding against that branch type. If the pair is not allowed, it raises a trap request together with a syndrome word. This check is meant to outrank every other decode of that instruction.

The branch-type register holds a nonzero value for one instruction at most. An instruction that loads a new branch type replaces the value. An instruction that traps, or that leaves through an exception, keeps it. Any other valid instruction clears it to zero. The trap request and the syndrome are registered and appear one clock after the valid strobe. Normal decode, page-table lookup, exception routing and the meaning of the signing hints are all outside this block.

Top module: `landing_check`

## Requirements
- R1: An instruction is in hint space when (insn & 0xFFFFF01F) == 0xD503201F, and its selector is then insn[11:5]. Selectors 0x19 and 0x1B (return-address signing hints) are compatible with every branch type, except branch type 3 while `chk_enable_i` is 1.
- R2: Hint selector 0x20 (bare pad) is incompatible with every nonzero branch type. Selector 0x22 (call pad) is incompatible only with type 3. Selector 0x24 (jump pad) is incompatible only with type 2. Selector 0x26 (call-or-jump pad) is compatible with all types. Every other hint selector is incompatible.
- R3: An instruction outside hint space with (insn & 0xFFE0001F) equal to 0xD4200000 (breakpoint) or 0xD4400000 (halt) is compatible. Every other instruction is incompatible.
- R4: `trap_o` is 1 in the cycle after a valid instruction exactly when that instruction met a nonzero branch type on a guarded page and was incompatible. A cycle with `insn_valid_i` low gives `trap_o` = 0 in the next cycle.
- R5: While `trap_o` is 1, `syndrome_o[31:26]` = 0x0D, `syndrome_o[25:2]` = 0 and `syndrome_o[1:0]` = the branch type the instruction met. While `trap_o` is 0, `syndrome_o` is 0.
- R6: A valid instruction that does not trap, does not set the branch type and does not leave by exception clears the branch type to 0 for the next cycle.
- R7: A valid, non-trapping instruction with `sets_bt_i` = 1 loads `new_bt_i` into the branch type, and this load takes priority over the clear and over `exc_taken_i`.
- R8: A trapping instruction leaves the branch type unchanged, even if `sets_bt_i` is 1. A non-trapping instruction with `exc_taken_i` = 1 and `sets_bt_i` = 0 also leaves it unchanged.
- R9: A synchronous active-high reset sets `bt_state_o`, `trap_o` and `syndrome_o` to 0.
- R10: A cycle with `insn_valid_i` = 0 leaves the branch type unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word being issued |
| insn_valid_i | input | 1 | Instruction issued this cycle |
| page_guarded_i | input | 1 | The instruction's page is guarded |
| chk_enable_i | input | 1 | Enable bit that makes the signing hints reject branch type 3 |
| sets_bt_i | input | 1 | This instruction writes a new branch type |
| new_bt_i | input | 2 | Branch type written when `sets_bt_i` is 1 |
| exc_taken_i | input | 1 | This instruction leaves by an exception |
| trap_o | output | 1 | Registered trap request |
| syndrome_o | output | 32 | Registered syndrome word |
| bt_state_o | output | 2 | Current branch-type register |

## Verification
The assertions rely on a few things about the inputs. `sets_bt_i`, `new_bt_i` and `exc_taken_i` are taken to be meaningful only in cycles with `insn_valid_i` high. Reset is taken to be held for at least one clock edge before any instruction arrives. The stimulus keeps to this. Every table case first issues an unguarded loader instruction that writes the wanted branch type and then issues the landing instruction, so the value checked after one cycle follows from only those two instructions. The directed tests set up exception exits, idle cycles and loads during a trap with the same two-step pattern.

// File: rtl/landing_pkg.sv
package landing_pkg;
  localparam int INSN_W = 32;
  localparam logic [INSN_W-1:0] HINT_MASK  = 32'hFFFF_F01F;
  localparam logic [INSN_W-1:0] HINT_MATCH = 32'hD503_201F;
  localparam logic [INSN_W-1:0] DBG_MASK   = 32'hFFE0_001F;
  localparam logic [INSN_W-1:0] BRK_MATCH  = 32'hD420_0000;
  localparam logic [INSN_W-1:0] HLT_MATCH  = 32'hD440_0000;
  localparam int SEL_LSB = 5;
  localparam int SEL_W   = 7;

  localparam logic [SEL_W-1:0] SEL_SIGN_A = 7'h19;
  localparam logic [SEL_W-1:0] SEL_SIGN_B = 7'h1B;
  localparam logic [SEL_W-1:0] SEL_PAD    = 7'h20;
  localparam logic [SEL_W-1:0] SEL_PAD_C  = 7'h22;
  localparam logic [SEL_W-1:0] SEL_PAD_J  = 7'h24;
  localparam logic [SEL_W-1:0] SEL_PAD_JC = 7'h26;

  typedef enum logic [2:0] {
    LK_OTHER,
    LK_SIGN,
    LK_PAD,
    LK_PAD_C,
    LK_PAD_J,
    LK_PAD_JC,
    LK_DEBUG
  } land_kind_t;
endpackage

// File: rtl/landing_kind_decode.sv
module landing_kind_decode
  import landing_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output land_kind_t        kind
);
  logic             in_hint;
  logic [SEL_W-1:0] sel;

  assign in_hint = (insn & HINT_MASK) == HINT_MATCH;
  assign sel     = insn[SEL_LSB +: SEL_W];

  always_comb begin
    kind = LK_OTHER;
    if (in_hint) begin
      unique case (sel)
        SEL_SIGN_A, SEL_SIGN_B: kind = LK_SIGN;
        SEL_PAD:                kind = LK_PAD;
        SEL_PAD_C:              kind = LK_PAD_C;
        SEL_PAD_J:              kind = LK_PAD_J;
        SEL_PAD_JC:             kind = LK_PAD_JC;
        default:                kind = LK_OTHER;
      endcase
    end else if (((insn & DBG_MASK) == BRK_MATCH) ||
                 ((insn & DBG_MASK) == HLT_MATCH)) begin
      kind = LK_DEBUG;
    end
  end
endmodule

// File: rtl/landing_compat.sv
module landing_compat
  import landing_pkg::*;
#(
  parameter int BT_W = 2
) (
  input  land_kind_t      kind,
  input  logic            chk_enable,
  input  logic [BT_W-1:0] bt,
  output logic            ok
);
  localparam logic [BT_W-1:0] BT_CALL = BT_W'(2);
  localparam logic [BT_W-1:0] BT_ANY  = BT_W'(3);

  always_comb begin
    unique case (kind)
      LK_SIGN:   ok = !(chk_enable && bt == BT_ANY);
      LK_PAD:    ok = 1'b0;
      LK_PAD_C:  ok = bt != BT_ANY;
      LK_PAD_J:  ok = bt != BT_CALL;
      LK_PAD_JC: ok = 1'b1;
      LK_DEBUG:  ok = 1'b1;
      default:   ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/bt_state_reg.sv
module bt_state_reg #(
  parameter int BT_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic            trap,
  input  logic            sets_bt,
  input  logic [BT_W-1:0] new_bt,
  input  logic            exc_taken,
  output logic [BT_W-1:0] bt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bt <= '0;
    end else if (valid && !trap) begin
      if (sets_bt)        bt <= new_bt;
      else if (!exc_taken) bt <= '0;
    end
  end

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (valid && !trap && !sets_bt && !exc_taken) |=> (bt == '0));
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && !trap && sets_bt) |=> (bt == $past(new_bt)));
  p_hold_trap_r8: assert property (@(posedge clk) disable iff (rst)
    (valid && trap) |=> $stable(bt));
  p_hold_exc_r8: assert property (@(posedge clk) disable iff (rst)
    (valid && !trap && !sets_bt && exc_taken) |=> $stable(bt));
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(bt));
endmodule

// File: rtl/trap_out_reg.sv
module trap_out_reg #(
  parameter int              BT_W    = 2,
  parameter int              SYN_W   = 32,
  parameter int              EC_W    = 6,
  parameter logic [EC_W-1:0] EC_CODE = 6'h0D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             trap_now,
  input  logic [BT_W-1:0]  bt,
  output logic             trap_o,
  output logic [SYN_W-1:0] syndrome_o
);
  localparam int PAD_W = SYN_W - EC_W - BT_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o     <= 1'b0;
      syndrome_o <= '0;
    end else if (valid && trap_now) begin
      trap_o     <= 1'b1;
      syndrome_o <= {EC_CODE, {PAD_W{1'b0}}, bt};
    end else begin
      trap_o     <= 1'b0;
      syndrome_o <= '0;
    end
  end

  p_no_valid_r4: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !trap_o);
  p_trap_bt_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && trap_now) |=> (trap_o && syndrome_o[BT_W-1:0] == $past(bt)));
  p_class_r5: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (syndrome_o[SYN_W-1 -: EC_W] == EC_CODE &&
                syndrome_o[SYN_W-EC_W-1:BT_W] == '0 &&
                syndrome_o[BT_W-1:0] != '0));
  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !trap_o |-> (syndrome_o == '0));
endmodule

// File: rtl/landing_check.sv
module landing_check
  import landing_pkg::*;
#(
  parameter int              BT_W    = 2,
  parameter int              SYN_W   = 32,
  parameter int              EC_W    = 6,
  parameter logic [EC_W-1:0] EC_CODE = 6'h0D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      insn_i,
  input  logic             insn_valid_i,
  input  logic             page_guarded_i,
  input  logic             chk_enable_i,
  input  logic             sets_bt_i,
  input  logic [BT_W-1:0]  new_bt_i,
  input  logic             exc_taken_i,
  output logic             trap_o,
  output logic [SYN_W-1:0] syndrome_o,
  output logic [BT_W-1:0]  bt_state_o
);
  land_kind_t kind;
  logic       land_ok;
  logic       trap_now;

  landing_kind_decode u_decode (
    .insn (insn_i),
    .kind (kind)
  );

  landing_compat #(.BT_W(BT_W)) u_compat (
    .kind       (kind),
    .chk_enable (chk_enable_i),
    .bt         (bt_state_o),
    .ok         (land_ok)
  );

  assign trap_now = (bt_state_o != '0) && page_guarded_i && !land_ok;

  bt_state_reg #(.BT_W(BT_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .valid     (insn_valid_i),
    .trap      (trap_now),
    .sets_bt   (sets_bt_i),
    .new_bt    (new_bt_i),
    .exc_taken (exc_taken_i),
    .bt        (bt_state_o)
  );

  trap_out_reg #(
    .BT_W(BT_W), .SYN_W(SYN_W), .EC_W(EC_W), .EC_CODE(EC_CODE)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .valid      (insn_valid_i),
    .trap_now   (trap_now),
    .bt         (bt_state_o),
    .trap_o     (trap_o),
    .syndrome_o (syndrome_o)
  );

  p_unguarded_r4: assert property (@(posedge clk) disable iff (rst)
    (insn_valid_i && !page_guarded_i) |=> !trap_o);
  p_debug_ok_r3: assert property (@(posedge clk) disable iff (rst)
    (insn_valid_i && kind == LK_DEBUG) |=> !trap_o);
endmodule

// File: tb/landing_check_test.sv
module landing_check_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn_i = '0;
  logic        insn_valid_i = 1'b0;
  logic        page_guarded_i = 1'b0;
  logic        chk_enable_i = 1'b0;
  logic        sets_bt_i = 1'b0;
  logic [1:0]  new_bt_i = '0;
  logic        exc_taken_i = 1'b0;
  logic        trap_o;
  logic [31:0] syndrome_o;
  logic [1:0]  bt_state_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  landing_check uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [31:0] NOP_W = 32'hD503201F;
  localparam logic [31:0] MOV_W = 32'hAA0003E0;

  // {insn, guarded, enable, branch type, expected trap}
  localparam logic [36:0] VEC [NVEC] = '{
    {32'hD503233F, 1'b1, 1'b1, 2'd3, 1'b1},  // R1 sign A, enable, type 3
    {32'hD503233F, 1'b1, 1'b0, 2'd3, 1'b0},  // R1 sign A, no enable
    {32'hD503237F, 1'b1, 1'b1, 2'd2, 1'b0},  // R1 sign B, type 2
    {32'hD503237F, 1'b1, 1'b1, 2'd3, 1'b1},  // R1 sign B, type 3
    {32'hD503241F, 1'b1, 1'b0, 2'd1, 1'b1},  // R2 bare pad
    {32'hD503245F, 1'b1, 1'b0, 2'd3, 1'b1},  // R2 call pad, type 3
    {32'hD503245F, 1'b1, 1'b0, 2'd2, 1'b0},  // R2 call pad, type 2
    {32'hD503249F, 1'b1, 1'b0, 2'd2, 1'b1},  // R2 jump pad, type 2
    {32'hD503249F, 1'b1, 1'b0, 2'd3, 1'b0},  // R2 jump pad, type 3
    {32'hD50324DF, 1'b1, 1'b1, 2'd3, 1'b0},  // R2 call-or-jump, type 3
    {32'hD50324DF, 1'b1, 1'b0, 2'd1, 1'b0},  // R2 call-or-jump, type 1
    {32'hD4200020, 1'b1, 1'b0, 2'd2, 1'b0},  // R3 breakpoint
    {32'hD4400000, 1'b1, 1'b1, 2'd1, 1'b0},  // R3 halt
    {MOV_W,        1'b1, 1'b0, 2'd1, 1'b1},  // R3 ordinary instruction
    {MOV_W,        1'b0, 1'b0, 2'd3, 1'b0},  // R4 unguarded page
    {MOV_W,        1'b1, 1'b0, 2'd0, 1'b0},  // R4 branch type zero
    {32'hD503243F, 1'b1, 1'b0, 2'd1, 1'b1},  // R2 unlisted hint selector
    {32'hD4200001, 1'b1, 1'b0, 2'd1, 1'b1},  // R3 near-breakpoint, low bits set
    {32'hD503241F, 1'b1, 1'b1, 2'd0, 1'b0}   // R4 bare pad, type zero
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle and returns at the next falling edge.
  task automatic apply(input logic v, input logic [31:0] w, input logic g,
                       input logic en, input logic s, input logic [1:0] nb,
                       input logic ex);
    insn_valid_i = v; insn_i = w; page_guarded_i = g; chk_enable_i = en;
    sets_bt_i = s; new_bt_i = nb; exc_taken_i = ex;
    @(negedge clk);
  endtask

  task automatic preset(input logic [1:0] b);
    apply(1'b1, NOP_W, 1'b0, 1'b0, 1'b1, b, 1'b0);
  endtask

  function automatic logic [31:0] syn_of(input logic t, input logic [1:0] b);
    return t ? {6'h0D, 24'h0, b} : 32'h0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset trap", {31'h0, trap_o}, 32'h0);
    chk("R9 reset syndrome", syndrome_o, 32'h0);
    chk("R9 reset bt", {30'h0, bt_state_o}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] w;
      logic g, en, et;
      logic [1:0] b;
      {w, g, en, b, et} = VEC[i];
      preset(b);
      apply(1'b1, w, g, en, 1'b0, 2'd0, 1'b0);
      chk($sformatf("R4 trap (R1/R2/R3 matrix) vec %0d", i), {31'h0, trap_o}, {31'h0, et});
      chk($sformatf("R5 syndrome vec %0d", i), syndrome_o, syn_of(et, b));
      chk($sformatf("R6 R8 bt after vec %0d", i), {30'h0, bt_state_o},
          {30'h0, (et ? b : 2'd0)});
    end

    // R7: load a type from zero
    apply(1'b1, MOV_W, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    apply(1'b1, MOV_W, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0);
    chk("R7 load", {30'h0, bt_state_o}, 32'd2);

    // R8: exception exit holds, then R6 plain instruction clears
    apply(1'b1, MOV_W, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
    chk("R8 exception hold", {30'h0, bt_state_o}, 32'd2);
    apply(1'b1, MOV_W, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    chk("R6 clear", {30'h0, bt_state_o}, 32'd0);

    // R10: idle cycles with a would-trap instruction on the bus
    preset(2'd1);
    apply(1'b0, MOV_W, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0);
    chk("R10 idle bt", {30'h0, bt_state_o}, 32'd1);
    chk("R4 idle trap", {31'h0, trap_o}, 32'd0);
    apply(1'b0, MOV_W, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
    chk("R10 idle bt second", {30'h0, bt_state_o}, 32'd1);

    // R8: trap wins over a load on the same instruction
    apply(1'b1, MOV_W, 1'b1, 1'b0, 1'b1, 2'd3, 1'b0);
    chk("R8 trap with load trap", {31'h0, trap_o}, 32'd1);
    chk("R8 trap with load bt", {30'h0, bt_state_o}, 32'd1);
    chk("R5 trap with load syndrome", syndrome_o, syn_of(1'b1, 2'd1));

    // R7: load beats exception flag on a compatible landing
    apply(1'b1, 32'hD50324DF, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1);
    chk("R7 load over exception trap", {31'h0, trap_o}, 32'd0);
    chk("R7 load over exception bt", {30'h0, bt_state_o}, 32'd2);
    apply(1'b0, NOP_W, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    chk("R4 trap drops after idle", {31'h0, trap_o}, 32'd0);

    // R9: reset in mid-run
    rst = 1'b1;
    apply(1'b0, NOP_W, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    chk("R9 mid reset bt", {30'h0, bt_state_o}, 32'd0);
    rst = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule